// File: doc/BRIEF.md
# Dual-Channel Label-Filtered Word Holding Register

This block holds the most recent 32-bit word from each of two serial word receivers and presents it to a host on a 16-bit bus. Each receiver channel raises a one-cycle end-of-word strobe alongside its complete word. An optional label filter decides whether the strobe captures the word. When the filter is on, the word's bits 9 and 10 must equal two programmed match bits. When it is off, every strobe captures the word.

A captured word drives that channel's active-low ready output low. The host reads the word in two 16-bit halves. It asserts that channel's read enable and picks a half with a shared select input. Ready returns high only once both halves have been read, in either order. A newer qualifying word replaces an unread one without warning and restarts the half tracking. The filter enable and match bits sit in a small configuration register that a one-cycle write strobe loads.

Top module: `rwb_top`

## Requirements
- R1: With the filter enabled, an end-of-word strobe captures the word only if word bit 9 (vector index 8) equals `cfg_match[0]` and word bit 10 (index 9) equals `cfg_match[1]`. Any other word is ignored and leaves the stored word and ready state unchanged.
- R2: With the filter disabled, every end-of-word strobe captures the word.
- R3: A capture at a clock edge drives that channel's `rdy_n` low from that edge on.
- R4: While a channel is read, `rd_data` combinationally shows stored bits 1..16 (index 15:0) when `half_sel`=0, and bits 17..32 (index 31:16) when `half_sel`=1. It shows 0 when no read enable is asserted.
- R5: A read counts at the clock edge where it is asserted. `rdy_n` stays low until both halves have been read in either order, and it rises at the edge of the second distinct half.
- R6: A qualifying word that arrives before both halves are read replaces the stored word. It forgets any halves already read, and `rdy_n` stays low.
- R7: The two channels are independent. A capture or read on one channel leaves the other channel's `rdy_n` and data unchanged.
- R8: When both read enables are asserted together, `rd_data` shows channel A, `rd_conflict` is 1, and only channel A's read is counted.
- R9: The filter enable and match bits change only at an edge where `cfg_we` is 1.
- R10: After reset both `rdy_n` outputs are 1, `rd_conflict` is 0, and the filter is disabled with match bits 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dec_en | input | 1 | Label filter enable to load |
| cfg_match | input | 2 | Match bits to load (bit 0 vs word bit 9, bit 1 vs word bit 10) |
| eos_a | input | 1 | Channel A end-of-word strobe |
| word_a | input | 32 | Channel A received word |
| eos_b | input | 1 | Channel B end-of-word strobe |
| word_b | input | 32 | Channel B received word |
| rd_en_a | input | 1 | Channel A read enable |
| rd_en_b | input | 1 | Channel B read enable |
| half_sel | input | 1 | Half select: 0 lower, 1 upper |
| rd_data | output | 16 | Host read data |
| rd_conflict | output | 1 | Both read enables asserted together |
| rdy_n_a | output | 1 | Channel A word ready, active low |
| rdy_n_b | output | 1 | Channel B word ready, active low |

## Verification
`rd_data` and `rd_conflict` are combinational, so they are due in the same cycle as the enable and select. The bench samples them 1 ns after driving its inputs on the falling edge. Captures, counted reads and configuration loads all take effect at the next rising edge. Every check on `rdy_n`, and every check that a stimulus was ignored, is therefore sampled 1 ns after that rising edge, before any new stimulus is applied.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int LBL_LO = 8;  // vector index of word bit 9

  // capture rule: filter off, or both label bits equal the match bits
  function automatic logic label_ok(input logic [WORD_W-1:0] w,
                                    input logic en,
                                    input logic [1:0] m);
    return !en || (w[LBL_LO+1:LBL_LO] == m);
  endfunction

  function automatic logic [HALF_W-1:0] half_pick(input logic [WORD_W-1:0] w,
                                                  input logic sel);
    return sel ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
  endfunction
endpackage

// File: rtl/rwb_cfg.sv
module rwb_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       en_in,
  input  logic [1:0] match_in,
  output logic       en_q,
  output logic [1:0] match_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      match_q <= 2'b00;
    end else if (we) begin
      en_q    <= en_in;
      match_q <= match_in;
    end
  end

  // R9: configuration only moves under the write strobe
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable({en_q, match_q}));
endmodule

// File: rtl/rwb_channel.sv
module rwb_channel
  import rwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eos,
  input  logic [WORD_W-1:0] word_in,
  input  logic              dec_en,
  input  logic [1:0]        match,
  input  logic              rd_stb,
  input  logic              half_sel,
  output logic [WORD_W-1:0] word_q,
  output logic              rdy_n
);
  logic valid, got_lo, got_hi;
  logic accept, lo_hit, hi_hit, done;

  assign accept = eos && label_ok(word_in, dec_en, match);
  assign lo_hit = rd_stb && valid && !half_sel;
  assign hi_hit = rd_stb && valid && half_sel;
  assign done   = valid && (got_lo || lo_hit) && (got_hi || hi_hit);
  assign rdy_n  = !valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      valid  <= 1'b0;
      got_lo <= 1'b0;
      got_hi <= 1'b0;
    end else if (accept) begin
      word_q <= word_in;
      valid  <= 1'b1;
      got_lo <= 1'b0;
      got_hi <= 1'b0;
    end else if (done) begin
      valid  <= 1'b0;
      got_lo <= 1'b0;
      got_hi <= 1'b0;
    end else begin
      if (lo_hit) got_lo <= 1'b1;
      if (hi_hit) got_hi <= 1'b1;
    end
  end

  a_r3_capture_ready: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !rdy_n);
  a_r6_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> word_q == $past(word_in));
  a_r1_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(word_q));
  a_r5_hold_unread: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n && !rd_stb) |=> !rdy_n);
endmodule

// File: rtl/rwb_top.sv
module rwb_top
  import rwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_dec_en,
  input  logic [1:0]        cfg_match,
  input  logic              eos_a,
  input  logic [WORD_W-1:0] word_a,
  input  logic              eos_b,
  input  logic [WORD_W-1:0] word_b,
  input  logic              rd_en_a,
  input  logic              rd_en_b,
  input  logic              half_sel,
  output logic [HALF_W-1:0] rd_data,
  output logic              rd_conflict,
  output logic              rdy_n_a,
  output logic              rdy_n_b
);
  localparam int NCH = 2;

  logic              dec_en_q;
  logic [1:0]        match_q;
  logic              eos_v   [NCH];
  logic [WORD_W-1:0] word_v  [NCH];
  logic              rd_v    [NCH];
  logic [WORD_W-1:0] store_v [NCH];
  logic              rdyn_v  [NCH];

  rwb_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .en_in(cfg_dec_en),
    .match_in(cfg_match), .en_q(dec_en_q), .match_q(match_q)
  );

  assign rd_conflict = rd_en_a && rd_en_b;
  assign eos_v[0]  = eos_a;
  assign eos_v[1]  = eos_b;
  assign word_v[0] = word_a;
  assign word_v[1] = word_b;
  assign rd_v[0]   = rd_en_a;
  assign rd_v[1]   = rd_en_b && !rd_en_a;  // channel A wins a conflict

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    rwb_channel u_ch (
      .clk(clk), .rst_n(rst_n), .eos(eos_v[i]), .word_in(word_v[i]),
      .dec_en(dec_en_q), .match(match_q), .rd_stb(rd_v[i]),
      .half_sel(half_sel), .word_q(store_v[i]), .rdy_n(rdyn_v[i])
    );
  end

  assign rdy_n_a = rdyn_v[0];
  assign rdy_n_b = rdyn_v[1];

  always_comb begin
    if (rd_en_a)      rd_data = half_pick(store_v[0], half_sel);
    else if (rd_en_b) rd_data = half_pick(store_v[1], half_sel);
    else              rd_data = '0;
  end

  // R8: a conflicting read leaves channel B's ready state alone
  a_r8_b_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_conflict && !eos_b) |=> $stable(rdy_n_b));
  // R7: channel B ready does not fall without its own strobe
  a_r7_b_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (!eos_b && rdy_n_b) |=> rdy_n_b);
endmodule

// File: tb/tb_rwb_top.sv
module tb_rwb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_dec_en = 0;
  logic [1:0] cfg_match = 0;
  logic eos_a = 0, eos_b = 0, rd_en_a = 0, rd_en_b = 0, half_sel = 0;
  logic [31:0] word_a = 0, word_b = 0;
  logic [15:0] rd_data;
  logic rd_conflict, rdy_n_a, rdy_n_b;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  rwb_top dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic en, input logic [1:0] m);
    @(negedge clk); cfg_we = 1; cfg_dec_en = en; cfg_match = m;
    @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic send(input bit ch, input logic [31:0] w);
    @(negedge clk);
    if (ch) begin eos_b = 1; word_b = w; end else begin eos_a = 1; word_a = w; end
    @(posedge clk); #1 eos_a = 0; eos_b = 0;
  endtask

  task automatic rd(input bit ch, input bit sel, input logic [15:0] exp, input string tag);
    @(negedge clk);
    if (ch) rd_en_b = 1; else rd_en_a = 1;
    half_sel = sel;
    #1 chk(tag, rd_data, exp);
    @(posedge clk); #1 rd_en_a = 0; rd_en_b = 0;
  endtask

  task automatic t_reset;
    chk("R10 rdy_n_a", rdy_n_a, 1); chk("R10 rdy_n_b", rdy_n_b, 1);
    chk("R10 conflict", rd_conflict, 0); chk("R4 idle data", rd_data, 0);
  endtask

  task automatic t_unfiltered;
    send(0, 32'hDEAD_BEEF);
    chk("R2/R3 rdy_a low", rdy_n_a, 0); chk("R7 rdy_b high", rdy_n_b, 1);
    rd(0, 0, 16'hBEEF, "R4 lower half");
    chk("R5 still low", rdy_n_a, 0);
    rd(0, 0, 16'hBEEF, "R5 lower again");
    chk("R5 same half twice", rdy_n_a, 0);
    rd(0, 1, 16'hDEAD, "R4 upper half");
    chk("R5 rdy released", rdy_n_a, 1);
  endtask

  task automatic t_upper_first;
    send(1, 32'h1234_5678);
    chk("R7 rdy_a untouched", rdy_n_a, 1);
    rd(1, 1, 16'h1234, "R4 B upper");
    chk("R5 B still low", rdy_n_b, 0);
    rd(1, 0, 16'h5678, "R4 B lower");
    chk("R5 B released", rdy_n_b, 1);
  endtask

  task automatic t_filter;
    set_cfg(1, 2'b10);  // word index 9 must be 1, index 8 must be 0
    send(0, 32'h0000_0300);
    chk("R1 mismatch ignored", rdy_n_a, 1);
    send(0, 32'hAAAA_0200);
    chk("R1 match captured", rdy_n_a, 0);
    send(0, 32'hFFFF_0100);
    rd(0, 1, 16'hAAAA, "R1 reject keeps word");
    rd(0, 0, 16'h0200, "R1 lower");
    chk("R5 released", rdy_n_a, 1);
    set_cfg(0, 2'b00);
  endtask

  task automatic t_overwrite;
    send(0, 32'h1111_2222);
    rd(0, 0, 16'h2222, "R4 first lower");
    send(0, 32'h3333_4444);
    chk("R6 rdy kept low", rdy_n_a, 0);
    rd(0, 1, 16'h3333, "R6 new upper");
    chk("R6 half flags cleared", rdy_n_a, 0);
    rd(0, 0, 16'h4444, "R6 new lower");
    chk("R6 released", rdy_n_a, 1);
  endtask

  task automatic t_conflict;
    send(0, 32'hA1A1_A0A0);
    send(1, 32'hB1B1_B0B0);
    @(negedge clk); rd_en_a = 1; rd_en_b = 1; half_sel = 0;
    #1 chk("R8 shows A", rd_data, 16'hA0A0); chk("R8 flag", rd_conflict, 1);
    @(posedge clk); #1 rd_en_a = 0; rd_en_b = 0;
    rd(0, 1, 16'hA1A1, "R8 A upper");
    chk("R8 A released", rdy_n_a, 1);
    rd(1, 1, 16'hB1B1, "R8 B upper");
    chk("R8 B lower not counted", rdy_n_b, 0);
    rd(1, 0, 16'hB0B0, "R8 B lower");
    chk("R8 B released", rdy_n_b, 1);
  endtask

  task automatic t_cfg_gate;
    @(negedge clk); cfg_dec_en = 1; cfg_match = 2'b11;  // no write strobe
    @(posedge clk); #1;
    send(0, 32'h0000_0000);
    chk("R9 filter not loaded", rdy_n_a, 0);
    rd(0, 0, 16'h0000, "R9 lower"); rd(0, 1, 16'h0000, "R9 upper");
    set_cfg(1, 2'b11);
    send(0, 32'h0000_0000);
    chk("R9 filter loaded", rdy_n_a, 1);
  endtask

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #22 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_unfiltered();
    t_upper_first();
    t_filter();
    t_overwrite();
    t_conflict();
    t_cfg_gate();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule